// File: doc/BRIEF.md
# Saturating Doubling Multiply-Accumulate Long Unit

This block is a SIMD lane array. It takes two source vectors of signed narrow elements and one accumulator vector of signed wide elements. Each wide lane draws one narrow element from each source vector. For each operand, an instruction bit decides whether that element comes from the even (lower) or the odd (upper) narrow slot of the lane. The two elements are widened and multiplied, and the product is doubled with saturation. The doubled product is then added to or subtracted from the accumulator lane, again with saturation, and the result is written to the destination vector.

The controls come from a 32-bit instruction word, decoded inside the block. The decoder covers three variants: bottom-bottom, top-top and bottom-top. It also covers the accumulate and subtract forms and three element sizes. The register index fields of the instruction are passed through. Results are registered one cycle after the valid strobe. A sticky flag records any clamping. A word that does not decode, or that uses an unallocated size, raises an illegal pulse and changes nothing.

Top module: `sqdm_top`

## Requirements
- R1: After synchronous reset, `vd_o`, `sat_o`, `done_o`, `illegal_o` and all three index outputs are zero.
- R2: `done_o` is high in the cycle after `valid_i` is high, and low in every other cycle.
- R3: A legal word sets the operand slots as follows. When bits 15:12 are 0110, bit 10 picks the slot for both operands: 0 is the even narrow slot of the lane and 1 is the odd one. Bit 11 set selects subtract.
- R4: When bits 15:11 are 00001, operand n takes the even slot and operand m takes the odd slot. Bit 10 set selects subtract.
- R5: Size field bits 23:22 set the wide lane width: 1 gives 16, 2 gives 32 and 3 gives 64 bits. The narrow elements are half that width. Lane i occupies bits [i*W +: W].
- R6: The accumulate form writes sat(a + 2*n*m), clamped to the signed range of the wide width.
- R7: The subtract form writes sat(a - 2*n*m), clamped to the signed range of the wide width.
- R8: If both narrow inputs are the most negative value, the doubled product becomes the largest positive wide value. This saturation is flagged even when the accumulate step then stays in range.
- R9: `sat_o` is set when any lane of a legal operation clamps in either step. It stays set until reset.
- R10: A word is legal only when all of the following hold: bits 31:24 are 01000100, bit 21 is 0, size is not 0, and bits 15:10 match one of the two patterns. An illegal word pulses `illegal_o` together with `done_o`.
- R11: An illegal word leaves `vd_o`, `sat_o` and the index outputs unchanged.
- R12: A legal word loads `zd_o` from bits 4:0, `zn_o` from bits 9:5 and `zm_o` from bits 20:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| insn_i | input | 32 | Instruction word |
| vn_i | input | VLEN | Source vector n (narrow elements) |
| vm_i | input | VLEN | Source vector m (narrow elements) |
| va_i | input | VLEN | Accumulator vector (wide elements) |
| vd_o | output | VLEN | Registered destination vector |
| done_o | output | 1 | Result-valid pulse |
| illegal_o | output | 1 | Undecodable-word pulse |
| sat_o | output | 1 | Sticky saturation flag |
| zd_o | output | 5 | Destination register index |
| zn_o | output | 5 | Source n register index |
| zm_o | output | 5 | Source m register index |

## Verification
The clocked properties assume that `valid_i` is only raised after reset has been released. They also assume that the flag and destination hold their values whenever no legal operation is issued. The bench drives a strobe for exactly one cycle and then idles one cycle, so every result and every illegal pulse can be seen on its own. With 16-bit lanes, the operand sweep covers every pair of 8-bit values. The sweep rotates through all three slot variants and both forms. Wider sizes get biased random operands that favour the minimum, maximum and zero values, so both clamps and the doubling limit are reached.

// File: rtl/sqdm_pkg.sv
package sqdm_pkg;

    localparam int INSN_W = 32;
    localparam int IDX_W  = 5;
    localparam int N_SIZES = 3;

    localparam logic [7:0] OPC_MAJOR   = 8'b0100_0100;
    localparam logic [3:0] GRP_SAME    = 4'b0110;
    localparam logic [4:0] GRP_MIXED   = 5'b00001;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_H    = 2'd1,
        SZ_S    = 2'd2,
        SZ_D    = 2'd3
    } size_e;

    typedef struct packed {
        logic              legal;
        size_e             size;
        logic              sub;
        logic              sel_n;
        logic              sel_m;
        logic [IDX_W-1:0]  zd;
        logic [IDX_W-1:0]  zn;
        logic [IDX_W-1:0]  zm;
    } ctrl_t;

    function automatic logic [1:0] size_to_idx(input size_e s);
        case (s)
            SZ_S:    return 2'd1;
            SZ_D:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sqdm_decode.sv
module sqdm_decode
    import sqdm_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output ctrl_t             ctrl_o
);
    logic hdr_ok;
    logic grp_ok;

    always_comb begin
        ctrl_o       = '0;
        grp_ok       = 1'b0;
        ctrl_o.zd    = insn_i[4:0];
        ctrl_o.zn    = insn_i[9:5];
        ctrl_o.zm    = insn_i[20:16];
        ctrl_o.size  = size_e'(insn_i[23:22]);
        hdr_ok       = (insn_i[31:24] == OPC_MAJOR) && !insn_i[21]
                       && (insn_i[23:22] != 2'd0);
        if (insn_i[15:12] == GRP_SAME) begin
            grp_ok       = 1'b1;
            ctrl_o.sub   = insn_i[11];
            ctrl_o.sel_n = insn_i[10];
            ctrl_o.sel_m = insn_i[10];
        end else if (insn_i[15:11] == GRP_MIXED) begin
            grp_ok       = 1'b1;
            ctrl_o.sub   = insn_i[10];
            ctrl_o.sel_n = 1'b0;
            ctrl_o.sel_m = 1'b1;
        end
        ctrl_o.legal = hdr_ok && grp_ok;
    end
endmodule

// File: rtl/sqdm_lane.sv
module sqdm_lane #(
    parameter int NW = 8
) (
    input  logic [NW-1:0]   n_i,
    input  logic [NW-1:0]   m_i,
    input  logic [2*NW-1:0] a_i,
    input  logic            sub_i,
    output logic [2*NW-1:0] res_o,
    output logic            sat_o
);
    localparam int WW = 2 * NW;
    localparam logic [NW-1:0] N_MIN = {1'b1, {(NW-1){1'b0}}};
    localparam logic [WW-1:0] W_MAX = {1'b0, {(WW-1){1'b1}}};
    localparam logic [WW-1:0] W_MIN = {1'b1, {(WW-1){1'b0}}};

    logic signed [WW-1:0] n_x, m_x, prod;
    logic [WW-1:0]        dbl;
    logic                 dbl_sat;
    logic [WW:0]          a_x, d_x, acc;
    logic                 acc_ovf;

    always_comb begin
        n_x     = {{NW{n_i[NW-1]}}, n_i};
        m_x     = {{NW{m_i[NW-1]}}, m_i};
        prod    = n_x * m_x;
        dbl_sat = (n_i == N_MIN) && (m_i == N_MIN);
        dbl     = dbl_sat ? W_MAX : {prod[WW-2:0], 1'b0};
        a_x     = {a_i[WW-1], a_i};
        d_x     = {dbl[WW-1], dbl};
        acc     = sub_i ? (a_x - d_x) : (a_x + d_x);
        acc_ovf = acc[WW] != acc[WW-1];
        if (acc_ovf) res_o = acc[WW] ? W_MIN : W_MAX;
        else         res_o = acc[WW-1:0];
        sat_o   = dbl_sat | acc_ovf;
    end
endmodule

// File: rtl/sqdm_array.sv
module sqdm_array #(
    parameter int VLEN = 128,
    parameter int NW   = 8
) (
    input  logic [VLEN-1:0] vn_i,
    input  logic [VLEN-1:0] vm_i,
    input  logic [VLEN-1:0] va_i,
    input  logic            sub_i,
    input  logic            sel_n_i,
    input  logic            sel_m_i,
    output logic [VLEN-1:0] vd_o,
    output logic            sat_o
);
    localparam int WW    = 2 * NW;
    localparam int LANES = VLEN / WW;

    logic [LANES-1:0] lane_sat;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [NW-1:0] n_sel, m_sel;
        assign n_sel = sel_n_i ? vn_i[i*WW+NW +: NW] : vn_i[i*WW +: NW];
        assign m_sel = sel_m_i ? vm_i[i*WW+NW +: NW] : vm_i[i*WW +: NW];
        sqdm_lane #(.NW(NW)) i_lane (
            .n_i   (n_sel),
            .m_i   (m_sel),
            .a_i   (va_i[i*WW +: WW]),
            .sub_i (sub_i),
            .res_o (vd_o[i*WW +: WW]),
            .sat_o (lane_sat[i])
        );
    end

    assign sat_o = |lane_sat;
endmodule

// File: rtl/sqdm_top.sv
module sqdm_top
    import sqdm_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [31:0]      insn_i,
    input  logic [VLEN-1:0]  vn_i,
    input  logic [VLEN-1:0]  vm_i,
    input  logic [VLEN-1:0]  va_i,
    output logic [VLEN-1:0]  vd_o,
    output logic             done_o,
    output logic             illegal_o,
    output logic             sat_o,
    output logic [4:0]       zd_o,
    output logic [4:0]       zn_o,
    output logic [4:0]       zm_o
);
    ctrl_t           ctrl;
    logic [VLEN-1:0] res_w [N_SIZES];
    logic            sat_w [N_SIZES];
    logic [1:0]      sidx;

    sqdm_decode i_dec (
        .insn_i (insn_i),
        .ctrl_o (ctrl)
    );

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        sqdm_array #(.VLEN(VLEN), .NW(8 << g)) i_arr (
            .vn_i    (vn_i),
            .vm_i    (vm_i),
            .va_i    (va_i),
            .sub_i   (ctrl.sub),
            .sel_n_i (ctrl.sel_n),
            .sel_m_i (ctrl.sel_m),
            .vd_o    (res_w[g]),
            .sat_o   (sat_w[g])
        );
    end

    assign sidx = size_to_idx(ctrl.size);

    always_ff @(posedge clk) begin
        if (rst) begin
            vd_o      <= '0;
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            sat_o     <= 1'b0;
            zd_o      <= '0;
            zn_o      <= '0;
            zm_o      <= '0;
        end else begin
            done_o    <= valid_i;
            illegal_o <= valid_i && !ctrl.legal;
            if (valid_i && ctrl.legal) begin
                vd_o  <= res_w[sidx];
                sat_o <= sat_o | sat_w[sidx];
                zd_o  <= ctrl.zd;
                zn_o  <= ctrl.zn;
                zm_o  <= ctrl.zm;
            end
        end
    end

    p_done_after_valid_r2: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o);
    p_done_only_after_valid_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(valid_i));
    p_illegal_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> done_o);
    p_illegal_keeps_vd_r11: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable(vd_o) && $stable(zd_o));
    p_sat_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        sat_o |=> sat_o);
endmodule

// File: tb/test_sqdm_top.sv
`timescale 1ns/1ps
module test_sqdm_top;
    localparam int VLEN = 128;

    logic             clk = 1'b0;
    logic             rst;
    logic             valid_i;
    logic [31:0]      insn_i;
    logic [VLEN-1:0]  vn_i, vm_i, va_i;
    logic [VLEN-1:0]  vd_o;
    logic             done_o, illegal_o, sat_o;
    logic [4:0]       zd_o, zn_o, zm_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit sticky = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sqdm_top #(.VLEN(VLEN)) i_sqdm_top (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i),
        .vn_i(vn_i), .vm_i(vm_i), .va_i(va_i), .vd_o(vd_o),
        .done_o(done_o), .illegal_o(illegal_o), .sat_o(sat_o),
        .zd_o(zd_o), .zn_o(zn_o), .zm_o(zm_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            if (n_fail < 20)
                $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // variant: 0 same-bottom, 1 same-top, 2 mixed
    function automatic logic [31:0] mk(input int sz, input int variant, input bit sub,
                                       input logic [4:0] zd, input logic [4:0] zn,
                                       input logic [4:0] zm);
        logic [31:0] w;
        w = {8'b0100_0100, sz[1:0], 1'b0, zm, 6'b0, zn, zd};
        if (variant == 2) w[15:10] = {5'b00001, sub};
        else              w[15:10] = {4'b0110, sub, variant[0]};
        return w;
    endfunction

    function automatic logic signed [131:0] sx(input logic [VLEN-1:0] v, input int w);
        logic signed [131:0] t;
        t = '0;
        for (int b = 0; b < w; b++) t[b] = v[b];
        if (v[w-1]) t = t - (132'sd1 <<< w);
        return t;
    endfunction

    task automatic model(input logic [VLEN-1:0] vn, input logic [VLEN-1:0] vm,
                         input logic [VLEN-1:0] va, input int sz, input bit sub,
                         input int seln, input int selm,
                         output logic [VLEN-1:0] vd, output bit sat);
        int W, NW;
        logic signed [131:0] nn, mm, aa, d, r, maxv, minv;
        W = 8 << sz; NW = W / 2;
        maxv = (132'sd1 <<< (W - 1)) - 1;
        minv = -(132'sd1 <<< (W - 1));
        vd = '0; sat = 0;
        for (int i = 0; i < VLEN / W; i++) begin
            nn = sx(vn >> (i*W + seln*NW), NW);
            mm = sx(vm >> (i*W + selm*NW), NW);
            aa = sx(va >> (i*W), W);
            d = 2 * nn * mm;
            if (d > maxv) begin d = maxv; sat = 1; end
            r = sub ? aa - d : aa + d;
            if (r > maxv) begin r = maxv; sat = 1; end
            if (r < minv) begin r = minv; sat = 1; end
            for (int b = 0; b < W; b++) vd[i*W + b] = r[b];
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [VLEN-1:0] vn,
                         input logic [VLEN-1:0] vm, input logic [VLEN-1:0] va);
        @(negedge clk);
        insn_i = w; vn_i = vn; vm_i = vm; va_i = va; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic run_legal(input int sz, input int variant, input bit sub,
                             input logic [VLEN-1:0] vn, input logic [VLEN-1:0] vm,
                             input logic [VLEN-1:0] va, input string req);
        logic [VLEN-1:0] e; bit s; int sn, sm;
        logic [4:0] zd, zn, zm;
        sn = (variant == 1) ? 1 : 0;
        sm = (variant == 0) ? 0 : 1;
        zd = 5'($urandom); zn = 5'($urandom); zm = 5'($urandom);
        model(vn, vm, va, sz, sub, sn, sm, e, s);
        sticky = sticky | s;
        issue(mk(sz, variant, sub, zd, zn, zm), vn, vm, va);
        chk(vd_o == e, req, vd_o, e);
        chk(sat_o == sticky && done_o && !illegal_o, "R9 sat/done", {125'b0, sat_o, done_o, illegal_o}, {125'b0, sticky, 2'b10});
        chk({zd_o, zn_o, zm_o} == {zd, zn, zm}, "R12 index fields", {113'b0, zd_o, zn_o, zm_o}, {113'b0, zd, zn, zm});
    endtask

    function automatic logic [VLEN-1:0] rvec(input int w);
        logic [VLEN-1:0] v;
        logic [63:0] e;
        v = '0;
        for (int i = 0; i < VLEN / w; i++) begin
            case ($urandom % 6)
                0: e = 64'h1 << (w - 1);
                1: e = (64'h1 << (w - 1)) - 1;
                2: e = '0;
                3: e = '1;
                default: e = {$urandom, $urandom};
            endcase
            for (int b = 0; b < w; b++) v[i*w + b] = e[b];
        end
        return v;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        sticky = 0;
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VLEN-1:0] vn, vm, va, keep, e;
        logic [4:0] kz;
        bit s;
        valid_i = 0; insn_i = '0; vn_i = '0; vm_i = '0; va_i = '0;
        void'($urandom(7));
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(vd_o == '0 && !sat_o && !done_o && !illegal_o && zd_o == 0 && zn_o == 0 && zm_o == 0,
            "R1 reset state", vd_o, '0);

        // R2 done only one cycle
        run_legal(1, 0, 0, rvec(8), rvec(8), rvec(16), "R6 basic add");
        @(negedge clk);
        chk(!done_o, "R2 done low when idle", {127'b0, done_o}, '0);

        // R8 doubling saturation with in-range accumulate (a = -1 in every lane)
        do_reset();
        model({16{8'h80}}, {16{8'h80}}, '1, 1, 0, 0, 0, e, s);
        issue(mk(1, 0, 0, 1, 2, 3), {16{8'h80}}, {16{8'h80}}, '1);
        chk(vd_o == {8{16'h7ffe}}, "R8 doubled min*min", vd_o, {8{16'h7ffe}});
        chk(sat_o, "R8 flag", {127'b0, sat_o}, 1);
        // R9 stays set after benign operation
        issue(mk(1, 0, 0, 1, 2, 3), '0, '0, '0);
        chk(sat_o && vd_o == '0, "R9 sticky", {127'b0, sat_o}, 1);
        // R6 accumulate clamp only: 0x7f00 + 2*1*1... use a = 0x7fff
        do_reset();
        issue(mk(1, 0, 0, 0, 0, 0), {16{8'h01}}, {16{8'h01}}, {8{16'h7fff}});
        chk(vd_o == {8{16'h7fff}} && sat_o, "R6 add clamps to max", vd_o, {8{16'h7fff}});
        // R7 subtract clamp to min
        do_reset();
        issue(mk(1, 0, 1, 0, 0, 0), {16{8'h01}}, {16{8'h01}}, {8{16'h8000}});
        chk(vd_o == {8{16'h8000}} && sat_o, "R7 sub clamps to min", vd_o, {8{16'h8000}});
        do_reset();
        issue(mk(1, 0, 1, 0, 0, 0), {16{8'h02}}, {16{8'h03}}, {8{16'h0010}});
        chk(vd_o == {8{16'h0004}} && !sat_o, "R7 sub plain", vd_o, {8{16'h0004}});

        // R3/R4/R5/R6/R7 exhaustive 8-bit pair sweep
        for (int p = 0; p < 65536; p += 8) begin
            int variant; bit sub;
            vn = rvec(8); vm = rvec(8); va = rvec(16);
            variant = (p / 8) % 3;
            sub = ((p / 24) % 2) == 1;
            for (int k = 0; k < 8; k++) begin
                logic [15:0] q;
                int on, om;
                q = 16'(p + k);
                on = (variant == 1) ? 8 : 0;
                om = (variant == 0) ? 0 : 8;
                for (int b = 0; b < 8; b++) begin
                    vn[k*16 + on + b] = q[8 + b];
                    vm[k*16 + om + b] = q[b];
                end
            end
            run_legal(1, variant, sub, vn, vm, va,
                      variant == 2 ? "R4 mixed sweep 16" : "R3 same sweep 16");
        end

        // R5 wider sizes with biased random operands
        for (int sz = 2; sz <= 3; sz++) begin
            for (int t = 0; t < 1200; t++) begin
                run_legal(sz, t % 3, (t / 3) % 2 == 1, rvec(4 << sz), rvec(4 << sz),
                          rvec(8 << sz), sz == 2 ? "R5 size32" : "R5 size64");
            end
        end

        // R10/R11 illegal words leave state unchanged
        for (int c = 0; c < 5; c++) begin
            logic [31:0] w;
            w = mk(2, c % 3, 0, 5'd9, 5'd9, 5'd9);
            case (c)
                0: w[23:22] = 2'b00;
                1: w[21]    = 1'b1;
                2: w[31:24] = 8'h45;
                3: w[15:12] = 4'b0111;
                default: w[15:10] = 6'b000100;
            endcase
            keep = vd_o; kz = zd_o;
            issue(w, rvec(16), rvec(16), rvec(32));
            chk(illegal_o && done_o, "R10 illegal pulse", {126'b0, illegal_o, done_o}, 2'b11);
            chk(vd_o == keep && sat_o == sticky && zd_o == kz, "R11 state unchanged", vd_o, keep);
        end

        // R1 again after reset with flag set
        do_reset();
        @(negedge clk);
        chk(!sat_o && vd_o == '0, "R1 reset clears", vd_o, '0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule